// File: doc/BRIEF.md
# Bidirectional Bus Shift Register

An eight-stage storage register placed between two parallel ports, A and B. It also has a serial input and a serial output. It can carry a word from one port to the other in either direction. It can gather a serial stream into a parallel word shown on a port. It can hold (recirculate) its contents. It can take a parallel word in and then shift it out serially.

Four level controls set the operating mode:
- an A-port enable,
- a direction select,
- a parallel/serial select,
- a clocked/unclocked select for parallel loads.

A rising clock edge performs every synchronous transfer. Each port is modelled as an input vector, an output vector and an output-enable. The output-enable stands in for a three-state pad driver.

In unclocked parallel mode the register is transparent. The stored word and the driving port follow the selected input port in the same cycle. The word present at each rising edge is captured, so the last captured value stays held after the mode is left.

Top module: `bus_shift_reg`

## Requirements
- R1: While `rst_n` is 0 at a rising clock edge, all stages clear to 0. After the edge, `ser_out` and both enabled port outputs read 0.
- R2: With `par_sel`=0, each rising edge shifts the word one place toward bit 7. `ser_in` enters bit 0, and `async_sel` has no effect.
- R3: `ser_out` always equals bit 7 (the top bit) of the current word.
- R4: `b_oe` equals `dir_a2b` in every mode. `b_out` equals the word while `b_oe`=1 and is all zeros otherwise.
- R5: `a_oe` is 1 only when `a_en`=1 and `dir_a2b`=0. `a_out` equals the word while `a_oe`=1 and is all zeros otherwise.
- R6: With `par_sel`=1, `dir_a2b`=0 and `async_sel`=0, a rising edge loads `b_in`, whatever `a_en` is.
- R7: With `par_sel`=1, `dir_a2b`=1, `a_en`=1 and `async_sel`=0, a rising edge loads `a_in`.
- R8: With `par_sel`=1, `dir_a2b`=1 and `a_en`=0, the word is held and `a_in` is ignored.
- R9: With `par_sel`=1 and `async_sel`=1, the word and the outputs follow the selected source within the same cycle, with no clock edge. The value present at the last rising edge in this mode stays held after the mode is left.
- R10: In every synchronous mode (`par_sel`=0, or `par_sel`=1 with `async_sel`=0), changing the data inputs between clock edges leaves all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous clear |
| a_en | input | 1 | Lets the A port take part in transfers |
| dir_a2b | input | 1 | 1: A to B, 0: B to A |
| async_sel | input | 1 | 1: unclocked parallel transfer |
| par_sel | input | 1 | 1: parallel mode, 0: serial shift |
| ser_in | input | 1 | Serial data entering bit 0 |
| a_in | input | 8 | A-port input word |
| b_in | input | 8 | B-port input word |
| a_out | output | 8 | A-port output word, zero when disabled |
| a_oe | output | 1 | A-port drive enable |
| b_out | output | 8 | B-port output word, zero when disabled |
| b_oe | output | 1 | B-port drive enable |
| ser_out | output | 1 | Top bit of the word |

## Verification
The results arrive on two schedules:
- **Synchronous results** (shift, clocked load, hold and clear) appear one rising edge after the inputs that cause them. The output-enables depend only on the controls and respond in the same cycle.
- **Unclocked parallel results** appear in the same cycle, with no edge needed.

The bench drives inputs just after each falling edge and samples 2 ns later, then applies inverted data inputs mid-cycle and samples again. In synchronous modes that second sample must match the first. In the unclocked mode it must follow the new inputs. The original inputs are restored before the rising edge, where the reference model advances.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    OP_SHIFT  = 2'd0,
    OP_LOAD_B = 2'd1,
    OP_LOAD_A = 2'd2,
    OP_HOLD   = 2'd3
  } bsr_op_e;
endpackage

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
  import bsr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    a_en,
  input  logic    dir_a2b,
  input  logic    async_sel,
  input  logic    par_sel,
  output bsr_op_e op,
  output logic    transparent,
  output logic    a_oe,
  output logic    b_oe
);
  // Mode decode: serial ignores async_sel, parallel picks its source.
  always_comb begin
    if (!par_sel)         op = OP_SHIFT;
    else if (!dir_a2b)    op = OP_LOAD_B;
    else if (a_en)        op = OP_LOAD_A;
    else                  op = OP_HOLD;
  end

  assign transparent = par_sel & async_sel;
  assign b_oe        = dir_a2b;
  assign a_oe        = a_en & ~dir_a2b;

  AST_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_oe, b_oe})); // R5
endmodule

// File: rtl/bsr_store.sv
module bsr_store
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bsr_op_e          op,
  input  logic             transparent,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] word
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] src;

  // Shift toward the top bit, new bit at the bottom.
  function automatic logic [WIDTH-1:0] shift_up(input logic [WIDTH-1:0] w,
                                                input logic b);
    return {w[TOP-1:0], b};
  endfunction

  function automatic logic [WIDTH-1:0] pick_src(input bsr_op_e o,
                                                input logic [WIDTH-1:0] w,
                                                input logic b,
                                                input logic [WIDTH-1:0] pa,
                                                input logic [WIDTH-1:0] pb);
    case (o)
      OP_SHIFT:  return shift_up(w, b);
      OP_LOAD_B: return pb;
      OP_LOAD_A: return pa;
      default:   return w;
    endcase
  endfunction

  assign src  = pick_src(op, q_r, ser_in, a_in, b_in);
  assign word = transparent ? src : q_r;

  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= src;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (q_r == '0)); // R1
  AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SHIFT) |=> (q_r[0] == $past(ser_in))); // R2
  AST_LOAD_FROM_B: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD_B) |=> (q_r == $past(b_in))); // R6
  AST_LOAD_FROM_A: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD_A) |=> (q_r == $past(a_in))); // R7
  AST_RECIRC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_HOLD) |=> $stable(q_r)); // R8
endmodule

// File: rtl/bsr_port_drv.sv
module bsr_port_drv #(
  parameter int WIDTH = 8
) (
  input  logic             oe,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] pad_out
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign pad_out[i] = oe & word[i];
  end
endmodule

// File: rtl/bus_shift_reg.sv
module bus_shift_reg
  import bsr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_en,
  input  logic             dir_a2b,
  input  logic             async_sel,
  input  logic             par_sel,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe,
  output logic             ser_out
);
  bsr_op_e          op;
  logic             transparent;
  logic [WIDTH-1:0] word;

  bsr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_a2b(dir_a2b),
    .async_sel(async_sel), .par_sel(par_sel), .op(op),
    .transparent(transparent), .a_oe(a_oe), .b_oe(b_oe)
  );

  bsr_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .op(op), .transparent(transparent),
    .ser_in(ser_in), .a_in(a_in), .b_in(b_in), .word(word)
  );

  bsr_port_drv #(.WIDTH(WIDTH)) u_drv_a (.oe(a_oe), .word(word), .pad_out(a_out));
  bsr_port_drv #(.WIDTH(WIDTH)) u_drv_b (.oe(b_oe), .word(word), .pad_out(b_out));

  assign ser_out = word[WIDTH-1];

  AST_B_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (b_oe == dir_a2b)); // R4
endmodule

// File: tb/test_bus_shift_reg.sv
`timescale 1ns/1ps
module test_bus_shift_reg;
  logic       clk = 1'b0;
  logic       rst_n, a_en, dir_a2b, async_sel, par_sel, ser_in;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic       a_oe, b_oe, ser_out;

  int total = 0;
  int bad   = 0;
  logic [7:0] m_q = 8'h00;   // reference model state

  always #10 clk = ~clk;     // 50 MHz

  bus_shift_reg i_bus_shift_reg (
    .clk(clk), .rst_n(rst_n), .a_en(a_en), .dir_a2b(dir_a2b),
    .async_sel(async_sel), .par_sel(par_sel), .ser_in(ser_in),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe), .ser_out(ser_out)
  );

  // Parallel source chosen by the controls, from the requirements.
  function automatic logic [7:0] par_source(input logic [7:0] q);
    if (!dir_a2b) return b_in;       // R6
    if (a_en)     return a_in;       // R7
    return q;                        // R8
  endfunction

  function automatic logic [7:0] seen_word(input logic [7:0] q);
    if (par_sel && async_sel) return par_source(q);   // R9
    return q;
  endfunction

  task automatic check(input string tag);
    logic [7:0] w;
    logic       eao, ebo;
    logic [7:0] ea, eb;
    w   = seen_word(m_q);
    ebo = dir_a2b;
    eao = a_en && !dir_a2b;
    ea  = eao ? w : 8'h00;
    eb  = ebo ? w : 8'h00;
    total++;
    if (a_out !== ea || b_out !== eb || a_oe !== eao || b_oe !== ebo
        || ser_out !== w[7]) begin
      bad++;
      $display("FAIL %s: a_out=%h/%h a_oe=%b/%b b_out=%h/%h b_oe=%b/%b ser_out=%b/%b (actual/expected)",
               tag, a_out, ea, a_oe, eao, b_out, eb, b_oe, ebo, ser_out, w[7]);
    end
  endtask

  task automatic cyc(input logic r, input logic ae, input logic dr,
                     input logic as, input logic ps, input logic si,
                     input logic [7:0] a, input logic [7:0] b,
                     input string tag);
    @(negedge clk);
    rst_n = r; a_en = ae; dir_a2b = dr; async_sel = as; par_sel = ps;
    ser_in = si; a_in = a; b_in = b;
    #2 check(tag);
    #2 a_in = ~a; b_in = ~b; ser_in = ~si;
    #2 if (ps && as) check({tag, " R9 mid-cycle follow"});
       else          check({tag, " R10 mid-cycle stable"});
    #2 a_in = a; b_in = b; ser_in = si;
    #1 check(tag);
    @(posedge clk);
    if (!rst_n)       m_q = 8'h00;                 // R1
    else if (!par_sel) m_q = {m_q[6:0], ser_in};   // R2
    else               m_q = par_source(m_q);
  endtask

  initial begin
    #(20 * 5000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual hang, expected finish)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pat;
    rst_n = 1'b0; a_en = 1'b0; dir_a2b = 1'b1; async_sel = 1'b0;
    par_sel = 1'b0; ser_in = 1'b1; a_in = 8'h00; b_in = 8'h00;
    // R1: reset clears, even with shift data pending
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R1 reset");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, "R1 reset");
    // R2 R3 R4: serial shift-in shown on B, async_sel toggled has no effect
    pat = 8'b1011_0011;
    for (int i = 7; i >= 0; i--)
      cyc(1'b1, 1'b0, 1'b1, i[0], 1'b0, pat[i], 8'h00, 8'h00, "R2 R3 R4 serial");
    // R5: serial with B->A direction, A enabled then disabled
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, "R5 serial A out");
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 8'h11, 8'h22, "R5 serial both off");
    // R6: clocked load from B, with a_en either way
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hEE, 8'h5A, "R6 load B");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hEE, 8'hA7, "R6 load B a_en");
    // R7: clocked load from A
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h00, "R7 load A");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h3C, 8'hFF, "R7 load A");
    // R8: recirculate, A inputs ignored (clocked and unclocked)
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h81, "R8 hold");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h18, "R8 hold");
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'h55, 8'h18, "R8 hold unclocked");
    // R9: transparent loads from B, then A
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h96, "R9 transparent B");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'h4D, 8'h00, "R9 transparent A");
    // R9: value held after leaving the transparent mode
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R9 held after");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'hFF, "R9 held after");
    // R3: shift the held word out serially
    for (int i = 0; i < 8; i++)
      cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, "R3 shift out");
    // R1: reset mid-run
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, "R7 reload");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R1 reset mid-run");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, "R1 after reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule